// File: doc/BRIEF.md
# Capture/Compare Timer Counter

A 16-bit up-counter with two capture/compare channels. Each channel holds a 16-bit register that either acts as a compare value, raising an interrupt pulse when the counter reaches it, or as a capture register that latches the counter on a rising edge of its trigger pin. Channel 0's compare value can also serve as the period of the counter: in clear-on-match mode the counter goes back to zero on the step in which it equals that value, and then keeps counting.

The counter advances only on cycles where both the run enable and the count-pulse input are high, so an external prescaler or event source can drive the count pulse. A sticky overflow flag records the step from all ones to zero. Software writes and reads the channel registers through a single-cycle port with registered read data. Masking of the two interrupt pulses is left to logic outside the block.

Top module: `cct_timer`

## Requirements
- R1: After synchronous reset the counter, overflow flag, both interrupt pulses, both channel registers and the read data are all zero.
- R2: The counter adds one on each cycle where `run_en` and `cnt_pulse` are both high, holds when `run_en` is high and `cnt_pulse` is low, and returns to zero on any cycle where `run_en` is low.
- R3: With `clr_mode` = 0 (free running) the counter wraps from 16'hFFFF to 16'h0000, sets the overflow flag, and is never cleared by a channel 0 match.
- R4: With `clr_mode` = 1 the counter goes to zero on the count step in which it equals channel register 0 (channel 0 in compare mode), and counts up again from zero afterwards.
- R5: The overflow flag sets only on a count step out of 16'hFFFF; in clear-on-match mode this happens when channel register 0 holds 16'hFFFF, and the channel 0 interrupt pulses in that same step.
- R6: The overflow flag stays set until `ovf_clr` is high; a new overflow in the same cycle as `ovf_clr` wins and keeps the flag set.
- R7: A channel in compare mode (`cap_sel[i]` = 0) drives `irq[i]` high for one cycle, in the cycle after the count step whose pre-step counter equals its register, i.e. together with the clear in clear-on-match mode.
- R8: A register write to a compare-mode channel (`wr_en`, `wr_idx` = i) in the same cycle as that channel's match cancels the match: no interrupt and no clear.
- R9: A channel in capture mode (`cap_sel[i]` = 1) loads the current counter into its register on a rising edge of `trig[i]` seen while `run_en` is high, and pulses `irq[i]` in the next cycle; a write in the same cycle loses to the capture.
- R10: When a capture on the channel selected by `rd_idx` coincides with a read of it, the capture is performed and the read data for that read is zero.
- R11: The edge detector's remembered level resets to low and only tracks the pin while `run_en` is high, so a pin already high when the timer is first enabled is taken as a rising edge.
- R12: A write stores `wr_data` into the channel `wr_idx` (0 or 1) at the clock edge; a read with `rd_en` presents that channel's register on `rd_data` from the next cycle and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Timer enable; low holds the counter at zero |
| cnt_pulse | input | 1 | Count enable pulse |
| clr_mode | input | 1 | 1 = clear on channel 0 match, 0 = free running |
| cap_sel | input | 2 | Per-channel mode, 1 = capture, 0 = compare |
| trig | input | 2 | Capture trigger pins, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 1 | Channel selected for write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 1 | Channel selected for read |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| count | output | 16 | Current counter value |
| rd_data | output | 16 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 2 | Per-channel single-cycle interrupt pulses |

## Verification
The assertions assume that `rst` is held for at least one clock edge before any stimulus and that every input is stable around the active edge, with channel indices limited to 0 and 1. They also assume a software read or write lasts exactly one cycle, since a strobe held high would re-read or re-write each cycle. The stimulus drives every input on the falling edge from one task, one cycle per call, and keeps strobes to single cycles, so each property sees the same clean per-step relation the requirements describe.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int unsigned CCT_W   = 16;
    localparam int unsigned CCT_NCH = 2;

    typedef logic [CCT_W-1:0] cct_word_t;

    typedef enum logic {
        MODE_FREE  = 1'b0,
        MODE_CLEAR = 1'b1
    } cct_mode_e;

    typedef struct packed {
        logic step;
        logic at_top;
        logic clear;
        logic ovf_set;
    } cct_cnt_ctl_t;

    function automatic logic all_ones(input cct_word_t v);
        return &v;
    endfunction

endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det #(
    parameter int unsigned NPIN = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run_en,
    input  logic [NPIN-1:0] pins,
    output logic [NPIN-1:0] rise
);

    logic [NPIN-1:0] prev_lvl;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        // remembered level starts low; only tracks the pin while running
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_lvl[i] <= 1'b0;
            end else if (run_en) begin
                prev_lvl[i] <= pins[i];
            end
        end

        assign rise[i] = run_en & pins[i] & ~prev_lvl[i];

        assert_no_double_edge_R11: assert property (@(posedge clk) disable iff (rst)
            (run_en && pins[i]) |=> !rise[i]);
    end

endmodule

// File: rtl/cct_counter.sv
module cct_counter
    import cct_pkg::*;
#(
    parameter int unsigned W = CCT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run_en,
    input  logic         cnt_pulse,
    input  cct_mode_e    mode,
    input  logic         match0,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         step,
    output logic         ovf_flag
);

    cct_cnt_ctl_t ctl;

    always_comb begin
        ctl.step    = run_en & cnt_pulse;
        ctl.at_top  = &count;
        ctl.clear   = ctl.step & (mode == MODE_CLEAR) & match0;
        ctl.ovf_set = ctl.step & ctl.at_top;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            count <= '0;
        end else if (ctl.clear) begin
            count <= '0;
        end else if (ctl.step) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
        end else begin
            ovf_flag <= ctl.ovf_set | (ovf_flag & ~ovf_clr);
        end
    end

    assign step = ctl.step;

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count == '0));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (run_en && !cnt_pulse) |=> $stable(count));
    assert_ovf_set_R5: assert property (@(posedge clk) disable iff (rst)
        (run_en && cnt_pulse && (&count)) |=> ovf_flag);
    assert_ovf_only_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && !(run_en && cnt_pulse && (&count))) |=> !ovf_flag);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    assert_clear_on_match_R4: assert property (@(posedge clk) disable iff (rst)
        (run_en && cnt_pulse && mode == MODE_CLEAR && match0) |=> (count == '0));

endmodule

// File: rtl/cct_ccr_bank.sv
module cct_ccr_bank
    import cct_pkg::*;
#(
    parameter int unsigned W   = CCT_W,
    parameter int unsigned NCH = CCT_NCH,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   count,
    input  logic           step,
    input  logic [NCH-1:0] cap_sel,
    input  logic [NCH-1:0] rise,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic           rd_en,
    input  logic [IW-1:0]  rd_idx,
    output logic [NCH-1:0] match_hit,
    output logic [NCH-1:0] event_now,
    output logic [W-1:0]   rd_data
);

    logic [W-1:0]   ccr [NCH];
    logic [NCH-1:0] cap_now;
    logic [NCH-1:0] wr_hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_hit[i]    = wr_en && (wr_idx == IW'(i));
        assign cap_now[i]   = cap_sel[i] & rise[i];
        // a write to the same register this cycle masks the compare
        assign match_hit[i] = ~cap_sel[i] & step & (count == ccr[i]) & ~wr_hit[i];
        assign event_now[i] = cap_sel[i] ? rise[i] : match_hit[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                ccr[i] <= '0;
            end else if (cap_now[i]) begin
                ccr[i] <= count;
            end else if (wr_hit[i]) begin
                ccr[i] <= wr_data;
            end
        end

        assert_capture_load_R9: assert property (@(posedge clk) disable iff (rst)
            (cap_sel[i] && rise[i]) |=> (ccr[i] == $past(count)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= cap_now[rd_idx] ? '0 : ccr[rd_idx];
        end
    end

    assert_capture_beats_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cap_sel[rd_idx] && rise[rd_idx]) |=> (rd_data == '0));

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    input  logic                cnt_pulse,
    input  logic                clr_mode,
    input  logic [CCT_NCH-1:0]  cap_sel,
    input  logic [CCT_NCH-1:0]  trig,
    input  logic                wr_en,
    input  logic                wr_idx,
    input  logic [CCT_W-1:0]    wr_data,
    input  logic                rd_en,
    input  logic                rd_idx,
    input  logic                ovf_clr,
    output logic [CCT_W-1:0]    count,
    output logic [CCT_W-1:0]    rd_data,
    output logic                ovf_flag,
    output logic [CCT_NCH-1:0]  irq
);

    logic [CCT_NCH-1:0] rise;
    logic [CCT_NCH-1:0] match_hit;
    logic [CCT_NCH-1:0] event_now;
    logic               step;
    cct_mode_e          mode;

    assign mode = cct_mode_e'(clr_mode);

    cct_edge_det #(.NPIN(CCT_NCH)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .pins   (trig),
        .rise   (rise)
    );

    cct_counter #(.W(CCT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .cnt_pulse (cnt_pulse),
        .mode      (mode),
        .match0    (match_hit[0]),
        .ovf_clr   (ovf_clr),
        .count     (count),
        .step      (step),
        .ovf_flag  (ovf_flag)
    );

    cct_ccr_bank #(.W(CCT_W), .NCH(CCT_NCH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .count     (count),
        .step      (step),
        .cap_sel   (cap_sel),
        .rise      (rise),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_idx    (rd_idx),
        .match_hit (match_hit),
        .event_now (event_now),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= '0;
        end else begin
            irq <= event_now;
        end
    end

    for (genvar i = 0; i < CCT_NCH; i++) begin : g_chk
        assert_match_irq_R7: assert property (@(posedge clk) disable iff (rst)
            match_hit[i] |=> irq[i]);
        assert_write_masks_match_R8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_idx == 1'(i)) && !cap_sel[i]) |=> !irq[i]);
        assert_capture_irq_R9: assert property (@(posedge clk) disable iff (rst)
            (cap_sel[i] && rise[i]) |=> irq[i]);
    end

endmodule

// File: tb/test_cct_timer.sv
`timescale 1ns/1ps
module test_cct_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0, cnt_pulse = 1'b0, clr_mode = 1'b0;
    logic [1:0]  cap_sel = 2'b00, trig = 2'b00;
    logic        wr_en = 1'b0, wr_idx = 1'b0, rd_en = 1'b0, rd_idx = 1'b0, ovf_clr = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] count, rd_data;
    logic        ovf_flag;
    logic [1:0]  irq;

    always #2.5 clk = ~clk;

    cct_timer i_cct_timer (
        .clk(clk), .rst(rst), .run_en(run_en), .cnt_pulse(cnt_pulse),
        .clr_mode(clr_mode), .cap_sel(cap_sel), .trig(trig),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .ovf_clr(ovf_clr),
        .count(count), .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct {
        logic [1:0]  irq;
        logic        ovf;
        logic [15:0] cnt;
        logic        rdv;
        logic [15:0] rd;
        string       req;
    } item_t;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    // reference state, built from the requirements
    logic [15:0] m_cnt = 0;
    logic [15:0] m_r[2] = '{16'h0, 16'h0};
    logic        m_ovf = 0;
    logic [1:0]  m_prev = 2'b00;

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic cyc(logic run, logic pulse, logic mode, logic [1:0] csel,
                       logic [1:0] tr, logic wr, logic widx, logic [15:0] wd,
                       logic rd, logic ridx, logic oclr, string req);
        logic       stp;
        logic [1:0] e, hit, ev;
        logic [15:0] rdx, nxt;
        item_t it;
        @(negedge clk);
        run_en = run; cnt_pulse = pulse; clr_mode = mode; cap_sel = csel;
        trig = tr; wr_en = wr; wr_idx = widx; wr_data = wd;
        rd_en = rd; rd_idx = ridx; ovf_clr = oclr;
        stp = run && pulse;
        for (int i = 0; i < 2; i++) begin
            e[i]   = run && tr[i] && !m_prev[i];
            hit[i] = !csel[i] && stp && (m_cnt == m_r[i]) && !(wr && widx == 1'(i));
            ev[i]  = csel[i] ? e[i] : hit[i];
        end
        rdx = (csel[ridx] && e[ridx]) ? 16'h0 : m_r[ridx];
        if (!run)                 nxt = 16'h0;
        else if (mode && hit[0])  nxt = 16'h0;
        else if (stp)             nxt = m_cnt + 16'h1;
        else                      nxt = m_cnt;
        m_ovf = (stp && m_cnt == 16'hFFFF) || (m_ovf && !oclr);
        for (int i = 0; i < 2; i++) begin
            if (csel[i] && e[i])            m_r[i] = m_cnt;
            else if (wr && widx == 1'(i))   m_r[i] = wd;
            if (run)                        m_prev[i] = tr[i];
        end
        m_cnt = nxt;
        it.irq = ev; it.ovf = m_ovf; it.cnt = m_cnt; it.rdv = rd; it.rd = rdx; it.req = req;
        q.push_back(it);
    endtask

    task automatic step_n(int n, logic mode, logic [1:0] csel, string req);
        for (int k = 0; k < n; k++) cyc(1, 1, mode, csel, 2'b00, 0, 0, 16'h0, 0, 0, 0, req);
    endtask

    // monitor: sample just after the edge, compare with the scoreboard
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.req != "") begin
                    chk(it.req, "irq",   {14'h0, irq},      {14'h0, it.irq});
                    chk(it.req, "ovf",   {15'h0, ovf_flag}, {15'h0, it.ovf});
                    chk(it.req, "count", count,             it.cnt);
                    if (it.rdv) chk(it.req, "rd_data", rd_data, it.rd);
                end
            end
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        trig = 2'b01;              // pin 0 already high during reset (R11)
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1", "count", count, 16'h0);
        chk("R1", "ovf",   {15'h0, ovf_flag}, 16'h0);
        chk("R1", "irq",   {14'h0, irq}, 16'h0);
        chk("R1", "rd_data", rd_data, 16'h0);
        cyc(0, 0, 0, 2'b00, 2'b01, 0, 0, 16'h0, 1, 1, 0, "R1");
        // R11: first enable with pin high is a rising edge -> capture of 0
        cyc(1, 0, 0, 2'b11, 2'b01, 0, 0, 16'h0, 0, 0, 0, "R11");
        cyc(1, 0, 0, 2'b11, 2'b01, 0, 0, 16'h0, 0, 0, 0, "R11");
        // R12: writes then a read back
        cyc(1, 0, 0, 2'b00, 2'b00, 1, 0, 16'h0005, 0, 0, 0, "R12");
        cyc(1, 0, 0, 2'b00, 2'b00, 1, 1, 16'h0003, 0, 0, 0, "R12");
        cyc(1, 0, 0, 2'b00, 2'b00, 0, 0, 16'h0, 1, 1, 0, "R12");
        // R3/R7: free running, matches pulse irq but never clear
        step_n(8, 0, 2'b00, "R3");
        // R2: count pulse pattern
        for (int k = 0; k < 6; k++) cyc(1, k[0], 0, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 0, "R2");
        cyc(0, 1, 0, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 0, "R2");
        // R4/R7: clear on match with period 6
        step_n(14, 1, 2'b00, "R4");
        // R8: write on the match cycle suppresses clear and irq
        while (m_cnt != 16'h0005) step_n(1, 1, 2'b00, "R4");
        cyc(1, 1, 1, 2'b00, 2'b00, 1, 0, 16'h0005, 0, 0, 0, "R8");
        step_n(1, 1, 2'b00, "R8");
        cyc(0, 0, 1, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 0, "R2");
        // R3: full wrap in free mode
        while (m_cnt != 16'hFFFF) step_n(1, 0, 2'b00, "");
        step_n(1, 0, 2'b00, "R3");
        cyc(1, 0, 0, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 0, "R6");
        cyc(1, 0, 0, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 2'b00, 2'b00, 1, 0, 16'hFFFF, 0, 0, 0, "R5");
        // R5/R6: clear mode with period value all ones, clear strobe on the wrap
        while (m_cnt != 16'hFFFE) step_n(1, 1, 2'b00, "");
        step_n(1, 1, 2'b00, "R5");
        cyc(1, 1, 1, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 1, "R6");
        step_n(2, 1, 2'b00, "R4");
        cyc(1, 0, 1, 2'b00, 2'b00, 0, 0, 16'h0, 0, 0, 1, "R6");
        // R9/R10: capture mode
        step_n(4, 0, 2'b11, "R9");
        cyc(1, 1, 0, 2'b11, 2'b10, 1, 1, 16'hABCD, 0, 0, 0, "R9");
        cyc(1, 1, 0, 2'b11, 2'b10, 0, 0, 16'h0, 1, 1, 0, "R9");
        step_n(3, 0, 2'b11, "R9");
        cyc(1, 1, 0, 2'b11, 2'b01, 0, 0, 16'h0, 1, 0, 0, "R10");
        cyc(1, 1, 0, 2'b11, 2'b00, 0, 0, 16'h0, 1, 0, 0, "R10");
        cyc(1, 0, 0, 2'b11, 2'b00, 1, 1, 16'h1234, 0, 0, 0, "R12");
        cyc(1, 0, 0, 2'b11, 2'b00, 0, 0, 16'h0, 1, 1, 0, "R12");
        cyc(1, 0, 0, 2'b11, 2'b00, 0, 0, 16'h0, 0, 0, 0, "R12");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule